// File: doc/BRIEF.md
# One-Bit Zero-Lag Cross-Correlator

This block estimates the correlation between every pair of receiver channels whose signals have already been reduced to one bit. Each bit carries only the sign of the signal. Every clock, each channel supplies a word of W consecutive sign samples for its real (in-phase) stream and another for its imaginary (quadrature) stream. Multiplying two signs gives a positive result exactly when they match, so the product of two samples is the XNOR of their bits. The block forms this product at zero lag, meaning between samples that share a time index. For each word it counts how many of the W positions agree, and it adds that count to a wide accumulator.

The block keeps one accumulator for each of the four cross terms of every channel pair. With n channels that comes to 2·n·(n−1) accumulators. A programmable integration length sets how many valid words make up one period. When the last word of a period arrives, the block copies every total into holding registers, raises a one-cycle done pulse, and starts the next period from zero with no gap. Along with the agreement counts it reports the number of samples in the period, so downstream logic can form the signed estimate 2·agree − total. A synchronous clear input abandons the current period.

Top module: `onebit_xcorr`

## Requirements
- R1: Bit value 1 means a positive sample and 0 means a negative one. The per-sample product is 1 when the two bits are equal. A valid word adds the number of matching positions, from 0 to W, to its accumulator.
- R2: Correlation is at zero lag. Sample k of one channel is compared only with sample k of the other channel. Sample k of channel c sits at bit c·W+k of the re_bits and im_bits inputs.
- R3: There are 2·NCH·(NCH−1) accumulators.
  - Pairs (i, j) with i<j are numbered p = 0, 1, … with i as the outer loop and j as the inner loop, both ascending.
  - Within a pair, term t is: 0 for re_i·re_j, 1 for im_i·im_j, 2 for re_i·im_j, 3 for im_i·re_j.
  - Accumulator p·4+t occupies bits [(p·4+t)·ACCW +: ACCW] of dump_counts.
- R4: A word offered with in_valid low changes no accumulator, no sample count and no word count.
- R5: A period ends on the clock edge that takes its int_len-th valid word.
  - At that edge the holding registers receive the totals including that word, and dump_done is high for the following cycle.
  - The next period starts from zero, so back-to-back periods lose no word.
- R6: An int_len of 0 acts as 1, so every valid word ends a period.
- R7: dump_total reports the number of samples in the last dumped period, equal to W times the number of valid words in it.
- R8: A clear input that is high at a clock edge zeroes all accumulators, the sample count and the word count. Any word offered in that cycle is dropped. The holding registers keep their values and dump_done stays low.
- R9: Synchronous reset zeroes the holding registers and dump_total, and drives dump_done low.
- R10: Between period ends, dump_counts and dump_total hold their values. Accumulators are ACCW bits wide, 32 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the running period |
| in_valid | input | 1 | Qualifies re_bits and im_bits this cycle |
| re_bits | input | NCH·W | Real-stream sign words; channel c in bits [c·W +: W] |
| im_bits | input | NCH·W | Imaginary-stream sign words; same layout |
| int_len | input | LENW | Valid words per integration period (0 treated as 1) |
| dump_done | output | 1 | One-cycle pulse after a period ends |
| dump_counts | output | NACC·ACCW | Held agreement counts, one ACCW slice per accumulator |
| dump_total | output | ACCW | Held sample count of the last period |

## Verification
The hardest case is the edge where a period closes. At that edge the holding registers must take the running total plus the current word's contribution while the accumulator restarts from zero. A single misplaced word only shows up when periods run back to back with no idle cycle. The stimulus reaches this case by running long random streams with int_len set to 1, 0 and small odd values. It mixes in idle cycles and a clear pulse in the middle of a period, then compares every held count against a bench model after each clock.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

    // Cross-term selector within one channel pair.
    typedef enum logic [1:0] {
        TERM_RR = 2'd0,
        TERM_II = 2'd1,
        TERM_RI = 2'd2,
        TERM_IR = 2'd3
    } term_e;

    // Per-cycle command from the period controller to every accumulator.
    typedef struct packed {
        logic add;   // accumulate the current contribution
        logic dump;  // period ends on this word
        logic zero;  // clear request
    } ctl_t;

    function automatic int pair_count(input int n);
        return n * (n - 1) / 2;
    endfunction

    // Linear index of pair (i,j), i<j, i outer and j inner loop.
    function automatic int pair_index(input int i, input int j, input int n);
        return i * n - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned s;
        s = 0;
        for (int k = 0; k < 32; k++) s += {31'd0, v[k]};
        return s;
    endfunction

endpackage

// File: rtl/xcorr_term.sv
module xcorr_term #(
    parameter int W   = 14,
    parameter int PCW = $clog2(W + 1)
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [PCW-1:0] agree
);
    import xcorr_pkg::*;

    logic [31:0] match_w;

    always_comb begin
        match_w        = '0;
        match_w[W-1:0] = ~(a ^ b);
        agree          = PCW'(ones32(match_w));
    end

endmodule

// File: rtl/xcorr_ctl.sv
module xcorr_ctl #(
    parameter int LENW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [LENW-1:0]   int_len,
    output xcorr_pkg::ctl_t   ctl
);
    import xcorr_pkg::*;

    logic [LENW-1:0] cnt_q;
    logic [LENW-1:0] eff_len;
    logic            last_w;

    always_comb begin
        eff_len  = (int_len == '0) ? LENW'(1) : int_len;
        last_w   = ({1'b0, cnt_q} + (LENW+1)'(1)) >= {1'b0, eff_len};
        ctl.zero = clr;
        ctl.add  = in_valid && !clr;
        ctl.dump = in_valid && !clr && last_w;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)    cnt_q <= '0;
        else if (ctl.dump) cnt_q <= '0;
        else if (ctl.add)  cnt_q <= cnt_q + LENW'(1);
    end

    // The word count is back at zero right after a clear.
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);

    // Idle cycles leave the word count alone.
    assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/xcorr_acc.sv
module xcorr_acc #(
    parameter int ACCW = 32,
    parameter int INCW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  xcorr_pkg::ctl_t   ctl,
    input  logic [INCW-1:0]   inc,
    output logic [ACCW-1:0]   sum
);
    logic [ACCW-1:0] acc_q;

    assign sum = acc_q + ACCW'(inc);

    always_ff @(posedge clk) begin
        if (rst || ctl.zero) acc_q <= '0;
        else if (ctl.dump)   acc_q <= '0;
        else if (ctl.add)    acc_q <= sum;
    end

    assert_acc_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.zero |=> acc_q == '0);

    assert_acc_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.add && !ctl.zero) |=> $stable(acc_q));

    assert_acc_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.dump && !ctl.zero) |=> acc_q == '0);

endmodule

// File: rtl/onebit_xcorr.sv
module onebit_xcorr #(
    parameter int NCH  = 4,
    parameter int W    = 14,
    parameter int ACCW = 32,
    parameter int LENW = 32,
    localparam int NPAIR = xcorr_pkg::pair_count(NCH),
    localparam int NACC  = 4 * NPAIR,
    localparam int PCW   = $clog2(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic [NCH*W-1:0]     re_bits,
    input  logic [NCH*W-1:0]     im_bits,
    input  logic [LENW-1:0]      int_len,
    output logic                 dump_done,
    output logic [NACC*ACCW-1:0] dump_counts,
    output logic [ACCW-1:0]      dump_total
);
    import xcorr_pkg::*;

    ctl_t                 ctl;
    logic [NACC*ACCW-1:0] sum_flat;
    logic [ACCW-1:0]      tot_sum;

    xcorr_ctl #(.LENW(LENW)) ctl_i (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .int_len(int_len), .ctl(ctl)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ci
        for (genvar j = i + 1; j < NCH; j++) begin : g_cj
            localparam int P = pair_index(i, j, NCH);
            for (genvar t = 0; t < 4; t++) begin : g_term
                logic [W-1:0]   op_a, op_b;
                logic [PCW-1:0] agree;
                if (t == int'(TERM_RR)) begin : g_rr
                    assign op_a = re_bits[i*W +: W];
                    assign op_b = re_bits[j*W +: W];
                end else if (t == int'(TERM_II)) begin : g_ii
                    assign op_a = im_bits[i*W +: W];
                    assign op_b = im_bits[j*W +: W];
                end else if (t == int'(TERM_RI)) begin : g_ri
                    assign op_a = re_bits[i*W +: W];
                    assign op_b = im_bits[j*W +: W];
                end else begin : g_ir
                    assign op_a = im_bits[i*W +: W];
                    assign op_b = re_bits[j*W +: W];
                end
                xcorr_term #(.W(W), .PCW(PCW)) term_i (
                    .a(op_a), .b(op_b), .agree(agree)
                );
                xcorr_acc #(.ACCW(ACCW), .INCW(PCW)) acc_i (
                    .clk(clk), .rst(rst), .ctl(ctl), .inc(agree),
                    .sum(sum_flat[(P*4+t)*ACCW +: ACCW])
                );
            end
        end
    end

    // Sample counter shares the accumulator structure with a constant step.
    xcorr_acc #(.ACCW(ACCW), .INCW(PCW)) tot_i (
        .clk(clk), .rst(rst), .ctl(ctl), .inc(PCW'(W)), .sum(tot_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dump_done   <= 1'b0;
            dump_counts <= '0;
            dump_total  <= '0;
        end else begin
            dump_done <= ctl.dump;
            if (ctl.dump) begin
                dump_counts <= sum_flat;
                dump_total  <= tot_sum;
            end
        end
    end

    assert_done_after_word_R5: assert property (@(posedge clk) disable iff (rst)
        dump_done |-> $past(in_valid && !clr));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !ctl.dump |=> ($stable(dump_counts) && $stable(dump_total)));

    assert_total_whole_words_R7: assert property (@(posedge clk) disable iff (rst)
        dump_done |-> (dump_total != '0 && (dump_total % ACCW'(W)) == '0));

    assert_clear_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dump_done);

endmodule

// File: tb/onebit_xcorr_tb_top.sv
`timescale 1ns/1ps
module onebit_xcorr_tb_top;
    localparam int NCH  = 4;
    localparam int W    = 14;
    localparam int ACCW = 32;
    localparam int LENW = 32;
    localparam int NACC = 2 * NCH * (NCH - 1);

    logic                 clk = 1'b0;
    logic                 rst, clr, in_valid;
    logic [NCH*W-1:0]     re_bits, im_bits;
    logic [LENW-1:0]      int_len;
    logic                 dump_done;
    logic [NACC*ACCW-1:0] dump_counts;
    logic [ACCW-1:0]      dump_total;

    always #4 clk = ~clk;

    onebit_xcorr #(.NCH(NCH), .W(W), .ACCW(ACCW), .LENW(LENW)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .re_bits(re_bits), .im_bits(im_bits), .int_len(int_len),
        .dump_done(dump_done), .dump_counts(dump_counts), .dump_total(dump_total)
    );

    int checks = 0;
    int errors = 0;

    // Bench model state
    longint               acc_m [NACC];
    longint               tot_m, cnt_m;
    logic [NACC*ACCW-1:0] hold_m;
    logic [ACCW-1:0]      htot_m;
    logic                 done_m;

    task automatic chk(input string tag, input logic [NACC*ACCW-1:0] act,
                       input logic [NACC*ACCW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Agreement count of one term per R1/R2, pair numbering per R3.
    function automatic longint term_agree(input logic [NCH*W-1:0] r,
            input logic [NCH*W-1:0] m, input int i, input int j, input int t);
        longint s = 0;
        for (int k = 0; k < W; k++) begin
            logic x, y;
            case (t)
                0: begin x = r[i*W+k]; y = r[j*W+k]; end
                1: begin x = m[i*W+k]; y = m[j*W+k]; end
                2: begin x = r[i*W+k]; y = m[j*W+k]; end
                default: begin x = m[i*W+k]; y = r[j*W+k]; end
            endcase
            if (x == y) s++;
        end
        return s;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < NACC; a++) acc_m[a] = 0;
        tot_m = 0; cnt_m = 0; hold_m = '0; htot_m = '0; done_m = 1'b0;
    endtask

    task automatic model_step(input bit v, input bit c,
            input logic [NCH*W-1:0] r, input logic [NCH*W-1:0] m,
            input logic [LENW-1:0] len);
        longint eff;
        done_m = 1'b0;
        if (c) begin
            for (int a = 0; a < NACC; a++) acc_m[a] = 0;
            tot_m = 0; cnt_m = 0;
        end else if (v) begin
            int p = 0;
            for (int i = 0; i < NCH; i++)
                for (int j = i + 1; j < NCH; j++) begin
                    for (int t = 0; t < 4; t++)
                        acc_m[p*4+t] += term_agree(r, m, i, j, t);
                    p++;
                end
            tot_m += W; cnt_m++;
            eff = (len == 0) ? 1 : longint'(len);
            if (cnt_m >= eff) begin
                for (int a = 0; a < NACC; a++) begin
                    hold_m[a*ACCW +: ACCW] = ACCW'(acc_m[a]);
                    acc_m[a] = 0;
                end
                htot_m = ACCW'(tot_m);
                tot_m = 0; cnt_m = 0; done_m = 1'b1;
            end
        end
    endtask

    task automatic step(input string tag, input bit v, input bit c,
            input logic [NCH*W-1:0] r, input logic [NCH*W-1:0] m);
        in_valid = v; clr = c; re_bits = r; im_bits = m;
        @(posedge clk);
        @(negedge clk);
        model_step(v, c, r, m, int_len);
        chk({tag, " done"}, {{(NACC*ACCW-1){1'b0}}, dump_done},
            {{(NACC*ACCW-1){1'b0}}, done_m});
        chk({tag, " counts"}, dump_counts, hold_m);
        chk({tag, " total"}, {{(NACC*ACCW-ACCW){1'b0}}, dump_total},
            {{(NACC*ACCW-ACCW){1'b0}}, htot_m});
    endtask

    function automatic logic [NCH*W-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH*W-1:0] pat;
        void'($urandom(32'd1234));
        rst = 1'b1; clr = 1'b0; in_valid = 1'b0;
        re_bits = '0; im_bits = '0; int_len = 32'd4;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 reset counts", dump_counts, '0);
        chk("R9 reset done/total", {{(NACC*ACCW-ACCW-1){1'b0}}, dump_done, dump_total}, '0);

        // R1: all agree vs all disagree, 4-word period
        step("R1 ones", 1, 0, '1, '1);
        step("R1 zeros", 1, 0, '0, '0);
        step("R1 re!=im", 1, 0, '1, '0);
        step("R1 end", 1, 0, {NCH{14'h3FFF}}, {NCH{14'h0000}});

        // R2: same pattern shifted by one position in channel 1
        pat = '0;
        for (int c = 0; c < NCH; c++)
            pat[c*W +: W] = (c == 1) ? 14'h2AAA : 14'h1555;
        int_len = 32'd2;
        step("R2 shift", 1, 0, pat, pat);
        step("R2 shift end", 1, 0, pat, ~pat);

        // R3/R7: random stream, odd period
        int_len = 32'd7;
        for (int n = 0; n < 700; n++)
            step("R3 R7 random", 1, 0, rnd_word(), rnd_word());

        // R4: idle words with garbage data mixed in
        for (int n = 0; n < 300; n++)
            step("R4 idle mix", ($urandom % 3) != 0, 0, rnd_word(), rnd_word());

        // R5: back-to-back single-word periods
        int_len = 32'd1;
        for (int n = 0; n < 200; n++)
            step("R5 len1", 1, 0, rnd_word(), rnd_word());

        // R6: zero length acts as one
        int_len = 32'd0;
        for (int n = 0; n < 100; n++)
            step("R6 len0", ($urandom % 4) != 0, 0, rnd_word(), rnd_word());

        // R8: clear mid-period, holding keeps last dump
        int_len = 32'd5;
        for (int n = 0; n < 3; n++) step("R8 pre", 1, 0, rnd_word(), rnd_word());
        step("R8 clear", 1, 1, '1, '1);
        for (int n = 0; n < 5; n++) step("R8 post", 1, 0, rnd_word(), rnd_word());
        for (int n = 0; n < 400; n++)
            step("R8 R10 random", ($urandom % 5) != 0, ($urandom % 50) == 0,
                 rnd_word(), rnd_word());

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule